// File: doc/BRIEF.md
# Audio Frame Sequencer with Divider-Edge Gating

This block produces the slow timing enables for a four-channel sound generator. An external timer supplies a one-cycle pulse on every falling edge of a divider bit, nominally at 512 Hz. The sequencer walks an eight-position step index on each edge it services. Depending on the position, it issues single-cycle strobes that clock the channels' length counters, the pitch sweep unit and the volume envelopes.

Alongside the step index the block keeps a free-running 8-bit phase counter that counts serviced events. Its low bits give the channels their finer sub-phases: the parity used for the extra length tick on a trigger, a sweep sub-tick condition, and a 64 Hz envelope-decrement strobe. The phase counter is preset on power-up. If the divider bit is already high when power comes on, the block discards the first edge and leaves the phase counter unchanged on the event after it. The phase outputs can therefore run out of step with the step index.

Top module: `audio_frame_seq`

## Requirements
- R1: After reset, every strobe is low, the step index is 0, the phase counter is 0, and both sub-phase outputs are low.
- R2: Each serviced edge advances the step index by one, wrapping from 7 to 0. The new index is visible in the cycle after the edge pulse.
- R3: A serviced edge taken at step s gives one-cycle strobes in the next cycle. The length strobe fires when s is 0, 2, 4 or 6. The sweep strobe fires when s is 2 or 6. The envelope strobe fires when s is 7. No strobe fires without a serviced edge.
- R4: While the power input is low, no edge is serviced. Step index, phase counter and both skip flags are held at zero. An edge pulse in the same cycle as power-off has no effect.
- R5: On the cycle where power rises with the divider-high input low, step index and phase counter become 0 and no skip is armed. An edge in that same cycle is not serviced.
- R6: On the cycle where power rises with the divider-high input high, the step index becomes 0 and the phase counter becomes 1. The next edge then produces no strobe and changes neither the step index nor the phase counter.
- R7: The first serviced edge after a skipped edge leaves the phase counter unchanged but otherwise acts normally. Every other serviced edge adds one to the phase counter.
- R8: The envelope-decrement strobe fires in the cycle after a serviced edge when the low three bits of the updated phase counter are all ones.
- R9: The extra-length phase output equals bit 0 of the phase counter. The sweep sub-tick output is high when bits 1:0 of the phase counter are both ones.
- R10: The phase counter is 8 bits wide and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divFallPulse | input | 1 | One-cycle pulse on each falling edge of the divider bit |
| powerEn | input | 1 | Sound unit power enable (level) |
| divBitHigh | input | 1 | Current level of the divider bit, sampled when power rises |
| lenStrobe | output | 1 | Length-counter clock strobe |
| sweepStrobe | output | 1 | Sweep clock strobe |
| envStrobe | output | 1 | Envelope clock strobe |
| envDecStrobe | output | 1 | 64 Hz envelope-decrement strobe from the phase counter |
| extraLenPhase | output | 1 | Phase counter bit 0, used for the trigger-time extra length tick |
| sweepSubTick | output | 1 | High when the low two phase bits are both ones |
| stepIdx | output | 3 | Current step index |
| phaseCnt | output | 8 | Current phase counter |

## Verification
The assertions assume that the edge pulse is synchronous and never high in two consecutive cycles. Several of them use this to read each strobe as the result of exactly one pulse in the cycle before. The random stimulus inserts an edge only when the previous cycle had none, and it toggles power rarely, so long runs with power on carry the phase counter past its wrap. Directed sequences cover the cases random traffic seldom reaches: power-up with the divider high followed by a skipped edge and a non-incrementing edge, and an edge that lands in the cycle where power rises or falls.

// File: rtl/afs_pkg.sv
package afs_pkg;

  localparam int STEP_W  = 3;
  localparam int PHASE_W = 8;
  localparam int ENV_DEC_BITS = 3;
  localparam int SWEEP_SUB_BITS = 2;

  // Control to datapath strobes, all combinational for the current cycle.
  typedef struct packed {
    logic clearAll;     // power is off: hold everything at zero
    logic powerOnLoad;  // power rising this cycle: load start values
    logic presetOne;    // divider bit high at power-up: phase starts at one
    logic serviceEvt;   // this edge is serviced
    logic advancePhase; // serviced edge that also bumps the phase counter
  } seqCtrl_t;

  typedef struct packed {
    logic len;
    logic sweep;
    logic env;
  } stepFlags_t;

  // Decode of the eight-position step pattern.
  function automatic stepFlags_t decodeStep(input logic [STEP_W-1:0] s);
    stepFlags_t f;
    f.len   = (s[0] == 1'b0) && (s < 3'd7);
    f.sweep = (s == 3'd2) || (s == 3'd6);
    f.env   = (s == 3'd7);
    return f;
  endfunction

endpackage

// File: rtl/afs_ctrl.sv
module afs_ctrl
  import afs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     divFallPulse,
  input  logic     powerEn,
  input  logic     divBitHigh,
  output seqCtrl_t ctrl
);

  logic powerQ;
  logic skipFlag;
  logic noIncFlag;
  logic edgeLive;

  always_comb begin
    edgeLive          = powerEn && powerQ && divFallPulse;
    ctrl.clearAll     = !powerEn;
    ctrl.powerOnLoad  = powerEn && !powerQ;
    ctrl.presetOne    = powerEn && !powerQ && divBitHigh;
    ctrl.serviceEvt   = edgeLive && !skipFlag;
    ctrl.advancePhase = edgeLive && !skipFlag && !noIncFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerQ    <= 1'b0;
      skipFlag  <= 1'b0;
      noIncFlag <= 1'b0;
    end else begin
      powerQ <= powerEn;
      if (!powerEn) begin
        skipFlag  <= 1'b0;
        noIncFlag <= 1'b0;
      end else if (!powerQ) begin
        skipFlag  <= divBitHigh;
        noIncFlag <= 1'b0;
      end else if (edgeLive) begin
        if (skipFlag) begin
          skipFlag  <= 1'b0;
          noIncFlag <= 1'b1;
        end else begin
          noIncFlag <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/afs_datapath.sv
module afs_datapath
  import afs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqCtrl_t           ctrl,
  output logic               lenStrobe,
  output logic               sweepStrobe,
  output logic               envStrobe,
  output logic               envDecStrobe,
  output logic [STEP_W-1:0]  stepIdx,
  output logic [PHASE_W-1:0] phaseCnt
);

  localparam logic [PHASE_W-1:0] PHASE_ONE = PHASE_W'(1);

  logic [PHASE_W-1:0] nextPhase;
  stepFlags_t         curFlags;

  always_comb begin
    nextPhase = ctrl.advancePhase ? phaseCnt + PHASE_ONE : phaseCnt;
    curFlags  = decodeStep(stepIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx      <= '0;
      phaseCnt     <= '0;
      lenStrobe    <= 1'b0;
      sweepStrobe  <= 1'b0;
      envStrobe    <= 1'b0;
      envDecStrobe <= 1'b0;
    end else begin
      lenStrobe    <= 1'b0;
      sweepStrobe  <= 1'b0;
      envStrobe    <= 1'b0;
      envDecStrobe <= 1'b0;
      if (ctrl.clearAll) begin
        stepIdx  <= '0;
        phaseCnt <= '0;
      end else if (ctrl.powerOnLoad) begin
        stepIdx  <= '0;
        phaseCnt <= ctrl.presetOne ? PHASE_ONE : '0;
      end else if (ctrl.serviceEvt) begin
        stepIdx      <= stepIdx + STEP_W'(1);
        phaseCnt     <= nextPhase;
        lenStrobe    <= curFlags.len;
        sweepStrobe  <= curFlags.sweep;
        envStrobe    <= curFlags.env;
        envDecStrobe <= &nextPhase[ENV_DEC_BITS-1:0];
      end
    end
  end

endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq
  import afs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               divFallPulse,
  input  logic               powerEn,
  input  logic               divBitHigh,
  output logic               lenStrobe,
  output logic               sweepStrobe,
  output logic               envStrobe,
  output logic               envDecStrobe,
  output logic               extraLenPhase,
  output logic               sweepSubTick,
  output logic [STEP_W-1:0]  stepIdx,
  output logic [PHASE_W-1:0] phaseCnt
);

  seqCtrl_t ctrl;

  afs_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .divFallPulse (divFallPulse),
    .powerEn      (powerEn),
    .divBitHigh   (divBitHigh),
    .ctrl         (ctrl)
  );

  afs_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .lenStrobe    (lenStrobe),
    .sweepStrobe  (sweepStrobe),
    .envStrobe    (envStrobe),
    .envDecStrobe (envDecStrobe),
    .stepIdx      (stepIdx),
    .phaseCnt     (phaseCnt)
  );

  assign extraLenPhase = phaseCnt[0];
  assign sweepSubTick  = &phaseCnt[SWEEP_SUB_BITS-1:0];

endmodule

// File: rtl/audio_frame_seq_chk.sv
module audio_frame_seq_chk
  import afs_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               divFallPulse,
  input logic               powerEn,
  input logic               lenStrobe,
  input logic               sweepStrobe,
  input logic               envStrobe,
  input logic               envDecStrobe,
  input logic [STEP_W-1:0]  stepIdx,
  input logic [PHASE_W-1:0] phaseCnt
);

  AST_STROBE_ADVANCES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lenStrobe || envStrobe) |-> stepIdx == $past(stepIdx) + 3'd1); // R2

  AST_SWEEP_WITH_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    sweepStrobe |-> lenStrobe); // R3

  AST_ENV_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    envStrobe |-> !lenStrobe && stepIdx == 3'd0); // R3

  AST_STROBE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (lenStrobe || envStrobe) |-> $past(divFallPulse)); // R3

  AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (lenStrobe || envStrobe) |=> !(lenStrobe || envStrobe)); // R3

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !powerEn |=> stepIdx == 3'd0 && phaseCnt == 8'd0 && !lenStrobe && !envStrobe); // R4

  AST_PHASE_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    powerEn |=> (phaseCnt == $past(phaseCnt) || phaseCnt == $past(phaseCnt) + 8'd1)); // R7

  AST_ENVDEC_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    envDecStrobe |-> phaseCnt[2:0] == 3'd7); // R8

endmodule

bind audio_frame_seq audio_frame_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .divFallPulse (divFallPulse),
  .powerEn      (powerEn),
  .lenStrobe    (lenStrobe),
  .sweepStrobe  (sweepStrobe),
  .envStrobe    (envStrobe),
  .envDecStrobe (envDecStrobe),
  .stepIdx      (stepIdx),
  .phaseCnt     (phaseCnt)
);

// File: tb/tb_audio_frame_seq.sv
module tb_audio_frame_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic divFallPulse = 1'b0;
  logic powerEn = 1'b0;
  logic divBitHigh = 1'b0;
  logic lenStrobe, sweepStrobe, envStrobe, envDecStrobe;
  logic extraLenPhase, sweepSubTick;
  logic [2:0] stepIdx;
  logic [7:0] phaseCnt;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  audio_frame_seq dut (
    .clk(clk), .rstN(rstN), .divFallPulse(divFallPulse), .powerEn(powerEn),
    .divBitHigh(divBitHigh), .lenStrobe(lenStrobe), .sweepStrobe(sweepStrobe),
    .envStrobe(envStrobe), .envDecStrobe(envDecStrobe),
    .extraLenPhase(extraLenPhase), .sweepSubTick(sweepSubTick),
    .stepIdx(stepIdx), .phaseCnt(phaseCnt)
  );

  // Reference state, written from the requirements.
  bit       mPwr, mSkip, mNoInc;
  bit [2:0] mStep;
  bit [7:0] mPhase;
  bit       mLen, mSweep, mEnv, mEnvDec;
  bit       lastEdge;
  bit       sawWrap;

  function automatic bit expLen(input bit [2:0] s);
    return (s == 0) || (s == 2) || (s == 4) || (s == 6); // R3
  endfunction

  function automatic bit expSweep(input bit [2:0] s);
    return (s == 2) || (s == 6); // R3
  endfunction

  task automatic modelUpdate(input bit e, input bit p, input bit dh);
    mLen = 0; mSweep = 0; mEnv = 0; mEnvDec = 0;
    if (!p) begin                              // R4
      mPwr = 0; mStep = 0; mPhase = 0; mSkip = 0; mNoInc = 0;
    end else if (!mPwr) begin                  // R5, R6
      mPwr = 1; mStep = 0; mPhase = dh ? 8'd1 : 8'd0; mSkip = dh; mNoInc = 0;
    end else if (e) begin
      if (mSkip) begin                         // R6
        mSkip = 0; mNoInc = 1;
      end else begin
        if (mNoInc) mNoInc = 0;                // R7
        else begin
          if (mPhase == 8'd255) sawWrap = 1;   // R10
          mPhase = mPhase + 8'd1;
        end
        mLen    = expLen(mStep);
        mSweep  = expSweep(mStep);
        mEnv    = (mStep == 3'd7);
        mEnvDec = (mPhase[2:0] == 3'd7);       // R8
        mStep   = mStep + 3'd1;                // R2
      end
    end
  endtask

  task automatic chk1(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string ctx);
    chk1({ctx, "/R2"}, "stepIdx", stepIdx, mStep);
    chk1({ctx, "/R7"}, "phaseCnt", phaseCnt, mPhase);
    chk1({ctx, "/R3"}, "lenStrobe", lenStrobe, mLen);
    chk1({ctx, "/R3"}, "sweepStrobe", sweepStrobe, mSweep);
    chk1({ctx, "/R3"}, "envStrobe", envStrobe, mEnv);
    chk1({ctx, "/R8"}, "envDecStrobe", envDecStrobe, mEnvDec);
    chk1({ctx, "/R9"}, "extraLenPhase", extraLenPhase, mPhase[0]);
    chk1({ctx, "/R9"}, "sweepSubTick", sweepSubTick, mPhase[1:0] == 2'b11);
  endtask

  // One cycle: check the outcome of the previous inputs, then drive new ones.
  task automatic cyc(input bit e, input bit p, input bit dh, input string ctx);
    @(negedge clk);
    checkAll(ctx);
    if (lastEdge) e = 0;  // edge pulse never two cycles in a row
    divFallPulse = e; powerEn = p; divBitHigh = dh;
    lastEdge = e;
    modelUpdate(e, p, dh);
  endtask

  task automatic edges(input int n, input string ctx);
    for (int i = 0; i < n; i++) begin
      cyc(1, 1, 0, ctx);
      cyc(0, 1, 0, ctx);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, "R1");
    cyc(0, 0, 0, "R1");

    // R4: edges with power off do nothing
    cyc(1, 0, 0, "R4");
    cyc(0, 0, 1, "R4");

    // R5: power-up with divider low, edge in the power-up cycle ignored
    cyc(1, 1, 0, "R5");
    cyc(0, 1, 0, "R5");
    edges(10, "R2");

    // R4: edge in the power-off cycle
    cyc(1, 0, 0, "R4");
    cyc(0, 0, 0, "R4");

    // R6: power-up with divider high, skip then no-increment (R7)
    cyc(0, 1, 1, "R6");
    cyc(0, 1, 0, "R6");
    edges(1, "R6");
    edges(1, "R7");
    edges(9, "R8");

    // R6 again, power cycled back-to-back
    cyc(0, 0, 0, "R4");
    cyc(0, 1, 1, "R6");
    edges(3, "R7");

    // R10: run past the phase wrap
    edges(260, "R10");
    @(negedge clk);
    checkAll("R10");
    tests++;
    if (!sawWrap) begin
      fails++;
      $display("FAIL R10 wrap not reached actual=0 expected=1");
    end
    @(posedge clk);

    // Constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      bit e, p, dh;
      e  = ($urandom % 3) == 0;
      dh = $urandom % 2;
      p  = powerEn;
      if (($urandom % 400) == 0) p = !p;
      cyc(e, p, dh, "RND");
    end
    @(negedge clk);
    checkAll("END");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule